// File: doc/BRIEF.md
# Four-Channel Synthesizer Control Register Bank

This block is the software-visible control point for a frequency generator made of four digital synthesizer channels fed by one shared PLL. It answers word-addressed reads and writes on a simple single-cycle bus. It holds each channel's divider settings, the per-channel reset and standby controls, and the PLL power-down and feedback-divider settings. It also reports the PLL lock input on a status bit.

Each channel keeps two copies of its divider settings. Bus writes update only a working copy. The active copy, which drives the synthesizer, is reloaded from the working copy in one step when software raises that channel's program-enable bit. A running channel can therefore be retuned without passing through a mix of old and new settings. The synthesizer datapath and the PLL itself are outside this block. The active settings and control levels leave the block as ports.

Word map (word addresses): 0 is the shared control word, 1 is the PLL configuration word, 2 is the program-enable word, and `PARAM_BASE + n` is the parameter word of channel n. The default `PARAM_BASE` is 4. All other addresses are undecoded.

Top module: `synth_ctl_bank`

## Requirements
- R1: While `rst_n` is low, every output port is zero. After reset, every readable word reads zero apart from the lock status bit.
- R2: A write to channel n's parameter word stores bits 24:0 in that channel's working copy. A read of the word returns those 25 bits, with bits 31:25 reading zero.
- R3: A channel's active settings do not change unless the same clock edge carries a program-enable rising edge for that channel. Parameter writes alone leave them as they were.
- R4: A write to word 2 that sets bit n while bit n was clear loads the working copy of channel n into its active copy. The new values appear on the outputs after that same clock edge.
- R5: A write to word 2 that leaves bit n set, or that clears it, does not change channel n's active settings.
- R6: In the parameter word, bits 14:0 are the fine phase step, bits 19:15 the coarse divider and bits 23:20 the power-of-two output divider. These drive `chan_step_o`, `chan_coarse_o` and `chan_odiv_o`, packed with channel n at slice n.
- R7: Parameter bit 24 drives `chan_div3_n_o[n]`. A 0 inserts the divide by 3 and a 1 bypasses it.
- R8: In control word 0, bits 3:0 drive `chan_reset_o`, bits 11:8 drive `chan_standby_n_o` (a 0 means standby), and bit 12 drives `pll_pdn_o`. Each reads back where it was written.
- R9: Bit 24 of word 0 reads the current level of `pll_lock_i`. Writing bit 24 has no effect.
- R10: Bits 18:16 of word 1 drive `pll_fbdiv_o` and read back in the same position. Word 2 reads back its bits 3:0.
- R11: Undecoded addresses read as zero, and writes to them change no output and no readable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the address |
| pll_lock_i | input | 1 | PLL lock indication |
| chan_step_o | output | NCH*15 | Active fine phase steps |
| chan_coarse_o | output | NCH*5 | Active coarse dividers |
| chan_odiv_o | output | NCH*4 | Active output divider exponents |
| chan_div3_n_o | output | NCH | Active divide-by-3 bypass (0 = divide) |
| chan_reset_o | output | NCH | Per-channel reset |
| chan_standby_n_o | output | NCH | Per-channel standby, 0 = standby |
| pll_pdn_o | output | 1 | PLL power-down control |
| pll_fbdiv_o | output | 3 | PLL feedback divider |

## Verification
The bench uses the default parameters: four channels, a 4-bit address and a parameter base of 4. The 16-word space therefore contains the unused word 3 and words 8 to 15. Random traffic reaches both undecoded ranges, and it also reaches repeated, rising and falling program-enable patterns on all four channels, so shadow loading and its suppression are exercised on every slice of the packed outputs.

// File: rtl/synth_bank_pkg.sv
package synth_bank_pkg;
   localparam int STEP_W   = 15;
   localparam int COARSE_W = 5;
   localparam int ODIV_W   = 4;
   localparam int PARAM_W  = STEP_W + COARSE_W + ODIV_W + 1;

   localparam int CTL_RST_LSB  = 0;
   localparam int CTL_SBY_LSB  = 8;
   localparam int CTL_PDN_BIT  = 12;
   localparam int CTL_LOCK_BIT = 24;
   localparam int FB_LSB       = 16;
   localparam int FB_W         = 3;
   localparam int MAX_CH       = 4;

   typedef struct packed {
      logic                byp3;
      logic [ODIV_W-1:0]   odiv;
      logic [COARSE_W-1:0] coarse;
      logic [STEP_W-1:0]   step;
   } chan_param_t;
endpackage

// File: rtl/synth_bank_decode.sv
module synth_bank_decode #(
   parameter int ADDR_W     = 4,
   parameter int NCH        = 4,
   parameter int PARAM_BASE = 4
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_ctl,
   output logic              hit_pll,
   output logic              hit_prog,
   output logic [NCH-1:0]    hit_param
);
   assign hit_ctl  = sel && (addr == ADDR_W'(0));
   assign hit_pll  = sel && (addr == ADDR_W'(1));
   assign hit_prog = sel && (addr == ADDR_W'(2));

   for (genvar g = 0; g < NCH; g++) begin : g_hit
      assign hit_param[g] = sel && (addr == ADDR_W'(PARAM_BASE + g));
   end
endmodule

// File: rtl/synth_chan_regs.sv
module synth_chan_regs
   import synth_bank_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_work,
   input  chan_param_t wdata,
   input  logic        load,
   output chan_param_t work,
   output chan_param_t act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work <= '0;
         act  <= '0;
      end else begin
         if (wr_work) work <= wdata;
         if (load)    act  <= work;
      end
   end
endmodule

// File: rtl/synth_ctl_bank.sv
module synth_ctl_bank
   import synth_bank_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int PARAM_BASE = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic                    pll_lock_i,
   output logic [NCH*STEP_W-1:0]   chan_step_o,
   output logic [NCH*COARSE_W-1:0] chan_coarse_o,
   output logic [NCH*ODIV_W-1:0]   chan_odiv_o,
   output logic [NCH-1:0]          chan_div3_n_o,
   output logic [NCH-1:0]          chan_reset_o,
   output logic [NCH-1:0]          chan_standby_n_o,
   output logic                    pll_pdn_o,
   output logic [FB_W-1:0]         pll_fbdiv_o
);
   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("synth_ctl_bank: NCH must be 1..4");
   end
   if (DATA_W < 32) begin : g_bad_dw
      $error("synth_ctl_bank: DATA_W must be at least 32");
   end
   if (PARAM_BASE < 3 || PARAM_BASE + NCH > (1 << ADDR_W)) begin : g_bad_base
      $error("synth_ctl_bank: parameter words must fit above word 2");
   end

   logic           hit_ctl, hit_pll, hit_prog;
   logic [NCH-1:0] hit_param;
   logic           wr_en;
   logic [NCH-1:0] prog_q;
   logic [NCH-1:0] load;
   logic [NCH-1:0] rst_q, sby_q;
   logic           pdn_q;
   logic [FB_W-1:0] fb_q;
   chan_param_t    work_v [NCH];
   chan_param_t    act_v  [NCH];
   logic [NCH*PARAM_W-1:0] work_flat, act_flat;
   logic           wdata_unused;

   assign wr_en        = bus_sel && bus_wr;
   assign wdata_unused = ^bus_wdata[DATA_W-1:PARAM_W];

   synth_bank_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .PARAM_BASE(PARAM_BASE)) i_dec (
      .sel       (bus_sel),
      .addr      (bus_addr),
      .hit_ctl   (hit_ctl),
      .hit_pll   (hit_pll),
      .hit_prog  (hit_prog),
      .hit_param (hit_param)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q  <= '0;
         sby_q  <= '0;
         pdn_q  <= 1'b0;
         fb_q   <= '0;
         prog_q <= '0;
      end else if (wr_en) begin
         if (hit_ctl) begin
            rst_q <= bus_wdata[CTL_RST_LSB +: NCH];
            sby_q <= bus_wdata[CTL_SBY_LSB +: NCH];
            pdn_q <= bus_wdata[CTL_PDN_BIT];
         end
         if (hit_pll)  fb_q   <= bus_wdata[FB_LSB +: FB_W];
         if (hit_prog) prog_q <= bus_wdata[NCH-1:0];
      end
   end

   assign load = {NCH{wr_en && hit_prog}} & bus_wdata[NCH-1:0] & ~prog_q;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      synth_chan_regs i_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_work (wr_en && hit_param[g]),
         .wdata   (chan_param_t'(bus_wdata[PARAM_W-1:0])),
         .load    (load[g]),
         .work    (work_v[g]),
         .act     (act_v[g])
      );
      assign work_flat[g*PARAM_W +: PARAM_W]   = work_v[g];
      assign act_flat[g*PARAM_W +: PARAM_W]    = act_v[g];
      assign chan_step_o[g*STEP_W +: STEP_W]   = act_v[g].step;
      assign chan_coarse_o[g*COARSE_W +: COARSE_W] = act_v[g].coarse;
      assign chan_odiv_o[g*ODIV_W +: ODIV_W]   = act_v[g].odiv;
      assign chan_div3_n_o[g]                  = act_v[g].byp3;
   end

   assign chan_reset_o     = rst_q;
   assign chan_standby_n_o = sby_q;
   assign pll_pdn_o        = pdn_q;
   assign pll_fbdiv_o      = fb_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_ctl) begin
         bus_rdata[CTL_RST_LSB +: NCH] = rst_q;
         bus_rdata[CTL_SBY_LSB +: NCH] = sby_q;
         bus_rdata[CTL_PDN_BIT]        = pdn_q;
         bus_rdata[CTL_LOCK_BIT]       = pll_lock_i;
      end
      if (hit_pll)  bus_rdata[FB_LSB +: FB_W] = fb_q;
      if (hit_prog) bus_rdata[NCH-1:0] = prog_q;
      for (int i = 0; i < NCH; i++) begin
         if (hit_param[i]) bus_rdata[PARAM_W-1:0] = work_v[i];
      end
   end
endmodule

// File: rtl/synth_bank_chk.sv
module synth_bank_chk
   import synth_bank_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int PARAM_BASE = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_sel,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic                   pll_lock_i,
   input logic [NCH-1:0]         prog_q,
   input logic [NCH*PARAM_W-1:0] work_flat,
   input logic [NCH*PARAM_W-1:0] act_flat
);
   logic prog_wr;
   logic decoded;
   assign prog_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(2));
   assign decoded = (int'(bus_addr) < 3) ||
                    (int'(bus_addr) >= PARAM_BASE && int'(bus_addr) < PARAM_BASE + NCH);

   // R3: without a program-enable write the active copies hold
   assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_wr |=> $stable(act_flat));

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      // R4: rising program-enable bit loads the working copy
      assert_load_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (prog_wr && bus_wdata[g] && !prog_q[g]) |=>
            (act_flat[g*PARAM_W +: PARAM_W] == $past(work_flat[g*PARAM_W +: PARAM_W])));
      // R5: held or falling bit leaves the channel unchanged
      assert_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (prog_wr && !(bus_wdata[g] && !prog_q[g])) |=>
            $stable(act_flat[g*PARAM_W +: PARAM_W]));
   end

   // R9: lock status mirrors the input on control-word reads
   assert_lock_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(0)) |-> (bus_rdata[CTL_LOCK_BIT] == pll_lock_i));

   // R11: undecoded words read zero
   assert_undecoded_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !decoded) |-> (bus_rdata == '0));
endmodule

bind synth_ctl_bank synth_bank_chk #(
   .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARAM_BASE(PARAM_BASE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pll_lock_i (pll_lock_i),
   .prog_q     (prog_q),
   .work_flat  (work_flat),
   .act_flat   (act_flat)
);

// File: tb/test_synth_ctl_bank.sv
`timescale 1ns/1ps
module test_synth_ctl_bank;
   localparam int NCH = 4;
   localparam int AW  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_lock_i = 1'b0;
   logic [NCH*15-1:0] chan_step_o;
   logic [NCH*5-1:0]  chan_coarse_o;
   logic [NCH*4-1:0]  chan_odiv_o;
   logic [NCH-1:0]    chan_div3_n_o, chan_reset_o, chan_standby_n_o;
   logic              pll_pdn_o;
   logic [2:0]        pll_fbdiv_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state
   logic [24:0] m_work [NCH];
   logic [24:0] m_act  [NCH];
   logic [31:0] m_ctl, m_pll, m_prog;

   always #2.5 clk = ~clk;

   synth_ctl_bank i_synth_ctl_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pll_lock_i(pll_lock_i), .chan_step_o(chan_step_o),
      .chan_coarse_o(chan_coarse_o), .chan_odiv_o(chan_odiv_o),
      .chan_div3_n_o(chan_div3_n_o), .chan_reset_o(chan_reset_o),
      .chan_standby_n_o(chan_standby_n_o), .pll_pdn_o(pll_pdn_o),
      .pll_fbdiv_o(pll_fbdiv_o)
   );

   function automatic logic [31:0] model_read(input logic [AW-1:0] a);
      int ia = int'(a);
      if (ia == 0) return (m_ctl & 32'h0000_1F0F) | (32'(pll_lock_i) << 24);
      if (ia == 1) return m_pll & 32'h0007_0000;
      if (ia == 2) return m_prog & 32'hF;
      if (ia >= 4 && ia < 4 + NCH) return {7'b0, m_work[ia-4]};
      return 32'h0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // model update on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin m_work[i] = '0; m_act[i] = '0; end
         m_ctl = '0; m_pll = '0; m_prog = '0;
      end else if (bus_sel && bus_wr) begin
         case (int'(bus_addr))
            0: m_ctl = bus_wdata;
            1: m_pll = bus_wdata;
            2: begin
               for (int i = 0; i < NCH; i++)
                  if (bus_wdata[i] && !m_prog[i]) m_act[i] = m_work[i];
               m_prog = bus_wdata & 32'hF;
            end
            default: if (int'(bus_addr) >= 4 && int'(bus_addr) < 4 + NCH)
               m_work[int'(bus_addr)-4] = bus_wdata[24:0];
         endcase
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int i = 0; i < NCH; i++) begin
            check("R3 R4 R6 step", 32'(chan_step_o[i*15 +: 15]), 32'(m_act[i][14:0]));
            check("R3 R4 R6 coarse", 32'(chan_coarse_o[i*5 +: 5]), 32'(m_act[i][19:15]));
            check("R3 R4 R6 odiv", 32'(chan_odiv_o[i*4 +: 4]), 32'(m_act[i][23:20]));
            check("R7 div3_n", 32'(chan_div3_n_o[i]), 32'(m_act[i][24]));
         end
         check("R8 reset", 32'(chan_reset_o), m_ctl[3:0]);
         check("R8 standby_n", 32'(chan_standby_n_o), m_ctl[11:8]);
         check("R8 pdn", 32'(pll_pdn_o), 32'(m_ctl[12]));
         check("R10 fbdiv", 32'(pll_fbdiv_o), 32'(m_pll[18:16]));
         if (bus_sel && !bus_wr) check("R2 R9 R10 R11 read", bus_rdata, model_read(bus_addr));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk); #1;
      bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 outputs", 32'(chan_step_o[31:0] | chan_coarse_o | chan_odiv_o), 32'h0);
      check("R1 ctl outs", {25'b0, pll_fbdiv_o, pll_pdn_o, chan_div3_n_o[0], chan_reset_o[0], chan_standby_n_o[0]}, 32'h0);
      #1 rst_n = 1;
      for (int a = 0; a < 16; a++) begin
         rd(a, r);
         check("R1 read after reset", r, 32'h0);
      end
      // R2, R3
      wr(4, 32'hFFFF_FFFF);
      rd(4, r);
      check("R2 readback", r, 32'h01FF_FFFF);
      check("R3 no load without strobe", 32'(chan_step_o[14:0]), 32'h0);
      // R4 R6 R7
      wr(2, 32'h1);
      check("R4 step loaded", 32'(chan_step_o[14:0]), 32'h7FFF);
      check("R6 coarse loaded", 32'(chan_coarse_o[4:0]), 32'h1F);
      check("R6 odiv loaded", 32'(chan_odiv_o[3:0]), 32'hF);
      check("R7 bypass set", 32'(chan_div3_n_o[0]), 32'h1);
      // R5
      wr(4, 32'h0012_3456);
      wr(2, 32'h1);
      check("R5 held bit no load", 32'(chan_step_o[14:0]), 32'h7FFF);
      wr(2, 32'h0);
      check("R5 falling bit no load", 32'(chan_step_o[14:0]), 32'h7FFF);
      wr(2, 32'h1);
      check("R4 reload", 32'(chan_step_o[14:0]), 32'h3456);
      // R8 R9
      pll_lock_i = 0;
      wr(0, 32'hFFFF_FFFF);
      check("R8 reset bits", 32'(chan_reset_o), 32'hF);
      check("R8 standby bits", 32'(chan_standby_n_o), 32'hF);
      check("R8 pdn", 32'(pll_pdn_o), 32'h1);
      rd(0, r);
      check("R9 lock low, write ignored", r, 32'h0000_1F0F);
      pll_lock_i = 1;
      rd(0, r);
      check("R9 lock high", r, 32'h0100_1F0F);
      // R10
      wr(1, 32'hFFFF_FFFF);
      check("R10 fbdiv", 32'(pll_fbdiv_o), 32'h7);
      rd(1, r);
      check("R10 fbdiv read", r, 32'h0007_0000);
      rd(2, r);
      check("R10 prog read", r, 32'h1);
      // R11
      wr(3, 32'hFFFF_FFFF);
      wr(12, 32'hFFFF_FFFF);
      rd(3, r);
      check("R11 word 3 zero", r, 32'h0);
      rd(12, r);
      check("R11 word 12 zero", r, 32'h0);
      rd(0, r);
      check("R11 ctl unchanged", r, 32'h0100_1F0F);
      // R7 divide inserted on channel 2; R3 other channels hold
      wr(6, 32'h00AB_CDEF & 32'h00FF_FFFF);
      wr(2, 32'h5);
      check("R7 divide by 3 inserted", 32'(chan_div3_n_o[2]), 32'h0);
      check("R3 channel 1 untouched", 32'(chan_step_o[29:15]), 32'h0);
      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk); #1;
         bus_sel    = ($urandom_range(0, 3) != 0);
         bus_wr     = $urandom_range(0, 1);
         bus_addr   = AW'($urandom_range(0, 15));
         bus_wdata  = $urandom;
         pll_lock_i = $urandom_range(0, 1);
      end
      @(negedge clk); #1;
      bus_sel = 0;
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule